// File: doc/BRIEF.md
# Low-Frequency Receiver Enable Sequencer

This block holds the 8-bit main control register of a low-frequency wake-up receiver and runs the power-up sequence of its analog front end. A processor reaches the register over a simple bus with an address, a write strobe, write data and combinational read data. When software sets the enable bit, the sequencer waits for a rising edge of the slow receiver oscillator. It then keeps the front end in a power-up phase for one whole oscillator cycle and runs an auto-zero phase timed in microsecond ticks. After that it raises a ready flag.

Clearing enable sends the sequencer into a hold state. The hold lasts two slow-oscillator rising edges, so the front end always gets a minimum off time. A new enable request written during the hold is kept and acted on once the hold is over. While the receiver is enabled, the mode, wake-up ID selection and sensitivity fields are locked, which keeps the front end out of undefined configurations. A self-clearing soft-reset bit returns the register and the sequencer to their reset state in one system clock.

Top module: `lfrx_enable_seq`

## Requirements
- R1: After reset all register fields read zero. At address CTRL_ADDR the read data is {enable[7], 0[6], carrier-mode[5], page[4], id-select[3:2], sensitivity[1:0]}. Bit 6 always reads 0. Any other address reads 0x00, and writes to other addresses change nothing.
- R2: seq_state encodes STANDBY=0, WAIT_EDGE=1, POWERUP=2, AUTOZERO=3, READY=4, OFF_HOLD=5. Setting enable in STANDBY moves to WAIT_EDGE on the next clock. WAIT_EDGE ends on an osc_rise strobe, moving to POWERUP with afe_en high.
- R3: POWERUP ignores us_tick and lasts until the next osc_rise strobe, which moves it to AUTOZERO with afe_autozero high.
- R4: AUTOZERO lasts exactly AZ_US us_tick strobes, then moves to READY with afe_ready high and afe_autozero low.
- R5: Clearing enable in WAIT_EDGE, POWERUP, AUTOZERO or READY moves to OFF_HOLD with afe_en low. OFF_HOLD returns to STANDBY on the HOLD_CYC-th osc_rise strobe. An enable set during the hold is deferred, and WAIT_EDGE follows one clock after STANDBY.
- R6: Writing 1 to bit 6 at CTRL_ADDR clears every field and forces STANDBY at that same clock edge, with all front-end outputs low.
- R7: While the stored enable bit is 1, writes leave carrier-mode, id-select and sensitivity unchanged. While it is 0, those fields take the written value.
- R8: The page bit is writable in any state. Its value changes neither the read nor the write access to the control register, nor the sequencer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Register bus address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| osc_rise | input | 1 | One-clock strobe per slow-oscillator rising edge |
| us_tick | input | 1 | One-clock strobe per microsecond |
| afe_en | output | 1 | Front-end power enable (POWERUP, AUTOZERO, READY) |
| afe_autozero | output | 1 | Auto-zero phase active |
| afe_ready | output | 1 | Receiver ready to receive |
| carrier_mode | output | 1 | Carrier-detect mode select |
| page_sel | output | 1 | Paged register window select |
| id_sel | output | 2 | Wake-up ID length/match select |
| sens_sel | output | 2 | Detection sensitivity select |
| seq_state | output | 3 | Sequencer state code |

## Verification
A wrong sequencer state shows on seq_state and the afe_* outputs one clock after the strobe or write that caused it. Because of this, every phase boundary is checked at the first negative edge after the triggering strobe. Skipped phases show up directly: an early afe_ready after too few ticks, or afe_en rising during the hold. A lost or leaked configuration write shows up on the field outputs and the read data in the very next cycle, so the lock and soft-reset behaviour is read back straight after each write.

// File: rtl/lfrx_pkg.sv
package lfrx_pkg;

    localparam int unsigned REG_W    = 8;
    localparam int unsigned B_EN     = 7;
    localparam int unsigned B_SRST   = 6;
    localparam int unsigned B_CMODE  = 5;
    localparam int unsigned B_PAGE   = 4;
    localparam int unsigned B_ID_HI  = 3;
    localparam int unsigned B_ID_LO  = 2;
    localparam int unsigned B_SEN_HI = 1;
    localparam int unsigned B_SEN_LO = 0;

    typedef enum logic [2:0] {
        ST_STANDBY   = 3'd0,
        ST_WAIT_EDGE = 3'd1,
        ST_POWERUP   = 3'd2,
        ST_AUTOZERO  = 3'd3,
        ST_READY     = 3'd4,
        ST_OFF_HOLD  = 3'd5
    } seq_state_e;

    typedef struct packed {
        logic       en;
        logic       cmode;
        logic       page;
        logic [1:0] idsel;
        logic [1:0] sens;
    } ctrl_fields_t;

endpackage

// File: rtl/lfrx_ctrl_reg.sv
module lfrx_ctrl_reg
    import lfrx_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_hit,
    input  logic [REG_W-1:0]   wdata,
    output ctrl_fields_t       fields,
    output logic               srst
);

    typedef struct packed {
        ctrl_fields_t f;
    } reg_st_t;

    reg_st_t st_d, st_q;

    assign srst   = wr_hit & wdata[B_SRST];
    assign fields = st_q.f;

    always_comb begin
        st_d = st_q;
        if (srst) begin
            st_d.f = '0;
        end else if (wr_hit) begin
            st_d.f.en   = wdata[B_EN];
            st_d.f.page = wdata[B_PAGE];
            if (!st_q.f.en) begin
                st_d.f.cmode = wdata[B_CMODE];
                st_d.f.idsel = wdata[B_ID_HI:B_ID_LO];
                st_d.f.sens  = wdata[B_SEN_HI:B_SEN_LO];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R7: configuration fields frozen while enabled
    p_cfg_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.f.en && !srst) |=> ($stable(st_q.f.cmode) && $stable(st_q.f.idsel)
                                  && $stable(st_q.f.sens)));

endmodule

// File: rtl/lfrx_evt_counter.sv
module lfrx_evt_counter #(
    parameter int unsigned LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    input  logic evt,
    output logic done
);

    localparam int unsigned W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    assign done = run && evt && !clr && (st_q.cnt == LAST);

    always_comb begin
        st_d = st_q;
        if (clr || !run) begin
            st_d.cnt = '0;
        end else if (evt) begin
            st_d.cnt = (st_q.cnt == LAST) ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4 / R5: each counted event advances the count by one
    p_cnt_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && evt && !clr && st_q.cnt != LAST) |=> (st_q.cnt == $past(st_q.cnt) + 1'b1));

endmodule

// File: rtl/lfrx_seq.sv
module lfrx_seq
    import lfrx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       srst,
    input  logic       en,
    input  logic       osc_rise,
    input  logic       az_done,
    input  logic       hold_done,
    output seq_state_e state
);

    typedef struct packed {
        seq_state_e s;
    } seq_st_t;

    seq_st_t st_d, st_q;

    assign state = st_q.s;

    always_comb begin
        st_d = st_q;
        if (srst) begin
            st_d.s = ST_STANDBY;
        end else begin
            unique case (st_q.s)
                ST_STANDBY:   if (en) st_d.s = ST_WAIT_EDGE;
                ST_WAIT_EDGE: begin
                    if (!en)          st_d.s = ST_OFF_HOLD;
                    else if (osc_rise) st_d.s = ST_POWERUP;
                end
                ST_POWERUP: begin
                    if (!en)          st_d.s = ST_OFF_HOLD;
                    else if (osc_rise) st_d.s = ST_AUTOZERO;
                end
                ST_AUTOZERO: begin
                    if (!en)         st_d.s = ST_OFF_HOLD;
                    else if (az_done) st_d.s = ST_READY;
                end
                ST_READY:     if (!en) st_d.s = ST_OFF_HOLD;
                ST_OFF_HOLD:  if (hold_done) st_d.s = ST_STANDBY;
                default:      st_d.s = ST_STANDBY;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{s: ST_STANDBY};
        else        st_q <= st_d;
    end

    // R2: standby is left only on an enable request
    p_standby_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.s == ST_STANDBY && !en && !srst) |=> (st_q.s == ST_STANDBY));

    // R3: an oscillator edge in power-up starts auto-zero
    p_powerup_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.s == ST_POWERUP && en && osc_rise && !srst) |=> (st_q.s == ST_AUTOZERO));

    // R5: hold is kept until the off-time counter completes
    p_hold_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.s == ST_OFF_HOLD && !hold_done && !srst) |=> (st_q.s == ST_OFF_HOLD));

endmodule

// File: rtl/lfrx_enable_seq.sv
module lfrx_enable_seq
    import lfrx_pkg::*;
#(
    parameter int unsigned ADDR_W    = 3,
    parameter int unsigned CTRL_ADDR = 0,
    parameter int unsigned AZ_US     = 64,
    parameter int unsigned HOLD_CYC  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              osc_rise,
    input  logic              us_tick,
    output logic              afe_en,
    output logic              afe_autozero,
    output logic              afe_ready,
    output logic              carrier_mode,
    output logic              page_sel,
    output logic [1:0]        id_sel,
    output logic [1:0]        sens_sel,
    output logic [2:0]        seq_state
);

    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

    logic         addr_hit;
    logic         wr_hit;
    logic         srst;
    ctrl_fields_t fields;
    seq_state_e   state;
    logic         az_done;
    logic         hold_done;

    assign addr_hit = (reg_addr == CTRL_A);
    assign wr_hit   = reg_wr && addr_hit;

    lfrx_ctrl_reg u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_hit (wr_hit),
        .wdata  (reg_wdata),
        .fields (fields),
        .srst   (srst)
    );

    lfrx_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .srst      (srst),
        .en        (fields.en),
        .osc_rise  (osc_rise),
        .az_done   (az_done),
        .hold_done (hold_done),
        .state     (state)
    );

    lfrx_evt_counter #(.LIMIT(AZ_US)) u_az_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (srst),
        .run   (state == ST_AUTOZERO),
        .evt   (us_tick),
        .done  (az_done)
    );

    lfrx_evt_counter #(.LIMIT(HOLD_CYC)) u_hold_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (srst),
        .run   (state == ST_OFF_HOLD),
        .evt   (osc_rise),
        .done  (hold_done)
    );

    always_comb begin
        reg_rdata = '0;
        if (addr_hit) begin
            reg_rdata[B_EN]              = fields.en;
            reg_rdata[B_CMODE]           = fields.cmode;
            reg_rdata[B_PAGE]            = fields.page;
            reg_rdata[B_ID_HI:B_ID_LO]   = fields.idsel;
            reg_rdata[B_SEN_HI:B_SEN_LO] = fields.sens;
        end
    end

    assign afe_en       = (state == ST_POWERUP) || (state == ST_AUTOZERO) || (state == ST_READY);
    assign afe_autozero = (state == ST_AUTOZERO);
    assign afe_ready    = (state == ST_READY);
    assign carrier_mode = fields.cmode;
    assign page_sel     = fields.page;
    assign id_sel       = fields.idsel;
    assign sens_sel     = fields.sens;
    assign seq_state    = state;

    // R6: soft reset clears register and sequencer at one edge
    p_soft_reset_r6: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (state == ST_STANDBY && fields == '0));

    // R4: ready only follows auto-zero or ready
    p_ready_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(afe_ready) |-> ($past(state) == ST_AUTOZERO));

endmodule

// File: tb/lfrx_enable_seq_tb.sv
module lfrx_enable_seq_tb;

    localparam int CLK_P = 10;
    localparam int AZ    = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       osc_rise = 1'b0;
    logic       us_tick = 1'b0;
    logic       afe_en, afe_autozero, afe_ready;
    logic       carrier_mode, page_sel;
    logic [1:0] id_sel, sens_sel;
    logic [2:0] seq_state;

    int total = 0;
    int bad   = 0;

    always #(CLK_P/2) clk = ~clk;

    lfrx_enable_seq #(.ADDR_W(3), .CTRL_ADDR(0), .AZ_US(AZ), .HOLD_CYC(2)) u_dut (
        .clk (clk), .rst_n (rst_n), .reg_addr (reg_addr), .reg_wr (reg_wr),
        .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .osc_rise (osc_rise),
        .us_tick (us_tick), .afe_en (afe_en), .afe_autozero (afe_autozero),
        .afe_ready (afe_ready), .carrier_mode (carrier_mode), .page_sel (page_sel),
        .id_sel (id_sel), .sens_sel (sens_sel), .seq_state (seq_state)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
        reg_addr = '0;
    endtask

    task automatic osc_pulse();
        @(negedge clk); osc_rise = 1'b1;
        @(negedge clk); osc_rise = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); us_tick = 1'b1;
            @(negedge clk); us_tick = 1'b0;
        end
    endtask

    task automatic run_to_ready();
        wr(3'd0, 8'h80); idle(1);
        osc_pulse(); osc_pulse(); ticks(AZ);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rd(3'd0, d);
        chk("R1 reset readback", d, 8'h00);
        chk("R1 reset state", seq_state, 0);
        chk("R1 reset afe", {afe_en, afe_autozero, afe_ready}, 0);
    endtask

    task automatic t_sequence();
        logic [7:0] d;
        wr(3'd0, 8'h80); idle(1);
        chk("R2 wait edge state", seq_state, 1);
        chk("R2 afe off while waiting", afe_en, 0);
        ticks(2);
        chk("R2 ticks do not start", seq_state, 1);
        osc_pulse();
        chk("R2 powerup state", seq_state, 2);
        chk("R2 afe_en in powerup", afe_en, 1);
        ticks(3);
        chk("R3 ticks ignored in powerup", seq_state, 2);
        osc_pulse();
        chk("R3 autozero state", seq_state, 3);
        chk("R3 autozero flag", afe_autozero, 1);
        ticks(AZ - 1);
        chk("R4 still autozero one tick short", seq_state, 3);
        chk("R4 not ready early", afe_ready, 0);
        ticks(1);
        chk("R4 ready state", seq_state, 4);
        chk("R4 ready flag", {afe_ready, afe_autozero, afe_en}, 3'b101);
        rd(3'd0, d);
        chk("R1 readback enabled", d, 8'h80);
    endtask

    task automatic t_lock_and_page();
        logic [7:0] d;
        wr(3'd0, 8'hAE);
        rd(3'd0, d);
        chk("R7 locked fields readback", d, 8'h80);
        chk("R7 locked outputs", {carrier_mode, id_sel, sens_sel}, 0);
        wr(3'd0, 8'h90);
        rd(3'd0, d);
        chk("R8 page write while enabled", d, 8'h90);
        chk("R8 page output", page_sel, 1);
        chk("R8 sequencer unaffected", seq_state, 4);
        wr(3'd0, 8'hB0);
        rd(3'd0, d);
        chk("R8 access with page set", d, 8'h90);
        wr(3'd0, 8'h80);
        chk("R8 page cleared", page_sel, 0);
    endtask

    task automatic t_disable_hold();
        logic [7:0] d;
        wr(3'd0, 8'h00); idle(1);
        chk("R5 off hold state", seq_state, 5);
        chk("R5 afe off in hold", afe_en, 0);
        wr(3'd0, 8'h2D);
        rd(3'd0, d);
        chk("R7 unlocked write", d, 8'h2D);
        chk("R7 unlocked outputs", {carrier_mode, id_sel, sens_sel}, 5'b1_11_01);
        wr(3'd0, 8'hAD); idle(1);
        chk("R5 set deferred", seq_state, 5);
        osc_pulse();
        chk("R5 still hold after one edge", seq_state, 5);
        chk("R5 afe off after one edge", afe_en, 0);
        osc_pulse(); idle(1);
        chk("R5 deferred restart", seq_state, 1);
        rd(3'd0, d);
        chk("R5 fields kept", d, 8'hAD);
    endtask

    task automatic t_soft_reset();
        logic [7:0] d;
        wr(3'd0, 8'h40);
        chk("R6 standby from wait", seq_state, 0);
        rd(3'd0, d);
        chk("R6 fields cleared", d, 8'h00);
        run_to_ready();
        chk("R6 ready before reset", seq_state, 4);
        wr(3'd0, 8'hFF);
        rd(3'd0, d);
        chk("R6 reset from ready readback", d, 8'h00);
        chk("R6 afe outputs low", {afe_en, afe_autozero, afe_ready}, 0);
        chk("R6 state standby", seq_state, 0);
        idle(2);
        chk("R6 stays standby", seq_state, 0);
    endtask

    task automatic t_other_addr();
        logic [7:0] d;
        wr(3'd1, 8'hFF); idle(1);
        rd(3'd1, d);
        chk("R1 other address reads zero", d, 8'h00);
        rd(3'd0, d);
        chk("R1 other address write ignored", d, 8'h00);
        chk("R1 no start from other address", seq_state, 0);
    endtask

    initial begin
        #(CLK_P * 200000);
        total++; bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle(2);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_sequence();
        t_lock_and_page();
        t_disable_hold();
        t_soft_reset();
        t_other_addr();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule